// File: doc/BRIEF.md
# Multi-Bridge Memory Window Decoder

This block sits on the host side of a system with two PCI host bridges and decides, for every host physical address, which agent claims it: system DRAM, the compatibility bridge (the one with the legacy devices below it), the auxiliary bridge, or nobody. Addresses are 36 bits wide, so the decoded space reaches 64 GiB. Each bridge owns a small set of memory windows. Firmware programs each window with an inclusive base page, an inclusive limit page and an enable bit, using a 1 MiB page size. A window with its enable bit clear, or with its limit below its base, claims nothing.

Two mode bits control what is left over. In single-bridge mode, any address that no higher-priority agent claims falls through to the compatibility bridge, which gives subtractive decode. In multi-bridge mode, the fall-through is off and a bridge receives only addresses that hit one of its windows. A separate high-range enable lets the compatibility bridge claim everything from the top of system memory to the end of the address space.

DRAM below the top of memory wins over everything. Next comes a fixed 1 MiB hole for the interrupt controller registers, which no bridge may claim. If an address hits windows of both bridges, an overlap error is flagged and neither bridge is selected. Software programs the block through a one-cycle register write port. Lookups are pipelined: one request can enter every cycle, and each answer appears one clock later.

Top module: `mwin_decoder`

## Requirements
- R1: After reset, the control, top-of-memory, enable and window registers are all zero, and `rsp_valid` is low. A lookup made with this state goes to the compatibility bridge, except in the excluded hole.
- R2: A lookup presented with `req_valid` high in one cycle produces `rsp_valid` high on the next clock edge. A cycle without `req_valid` produces `rsp_valid` low on the next edge. A new lookup may be issued every cycle.
- R3: If address bits [35:20] (the page) are below the top-of-memory page, the response is DRAM (`rsp_target` = 1), regardless of any window or mode.
- R4: A page at or above top of memory that falls in the excluded hole (page 0xFEC, addresses 0xFEC00000 to 0xFECFFFFF) returns no target (`rsp_target` = 0) and no overlap, in every mode and whatever windows cover it.
- R5: A page inside an enabled window claims the address for that window's bridge. The base and limit are inclusive page numbers. The compatibility bridge is `rsp_target` = 2 and the auxiliary bridge is `rsp_target` = 3.
- R6: A window whose limit is below its base matches no address.
- R7: A window whose enable bit is clear matches no address.
- R8: With the high-range enable set, every page at or above top of memory and outside the hole is claimed by the compatibility bridge. If an auxiliary window also matches, an overlap is flagged instead.
- R9: In single-bridge mode (control bit 0 = 0), an address that no window, no DRAM and no hole claims goes to the compatibility bridge.
- R10: In multi-bridge mode (control bit 0 = 1), an address that neither bridge claims returns no target and no overlap.
- R11: An address claimed by both bridges returns `rsp_overlap` = 1 with `rsp_target` = 0.
- R12: The register map is as follows:
  - Index 0 is the control register: bit 0 selects multi-bridge mode and bit 1 is the high-range enable.
  - Index 1 holds the top-of-memory page in bits [15:0].
  - Index 2 is the enable mask: bit w enables compatibility window w and bit 4+w enables auxiliary window w.
  - Indices 3 to 6 are compatibility windows 0 to 3, and indices 7 to 10 are auxiliary windows 0 to 3. Each holds the base page in bits [15:0] and the limit page in bits [31:16].
  
  A write affects lookups presented from the following cycle onward. A lookup presented in the same cycle as the write uses the old value.
- R13: A write to an index above 10 changes no decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 36 | Host physical address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_target | output | 2 | 0 none, 1 DRAM, 2 compatibility bridge, 3 auxiliary bridge |
| rsp_overlap | output | 1 | Address hit windows of both bridges |

## Verification
All three response outputs are due exactly one clock edge after the cycle in which the request was presented. The bench drives each request at a falling edge. It compares the answer at the next falling edge, and at that same edge it drives the next request, so back-to-back lookups are checked without gaps. A register write takes effect at the same rising edge that captures a lookup issued alongside it. For that reason the bench computes the expected answer of each lookup from its register model before it applies that cycle's write, which makes the same-cycle ordering of R12 part of every check.

// File: rtl/mwin_pkg.sv
// Shared types and register indices for the memory window decoder.
// Assumes the register file is indexed by small integers. Windows of
// both bridges follow the three fixed registers.
package mwin_pkg;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_DRAM   = 2'd1,
        TGT_COMPAT = 2'd2,
        TGT_AUX    = 2'd3
    } tgt_e;

    localparam int REG_CTRL = 0;
    localparam int REG_TOM  = 1;
    localparam int REG_EN   = 2;
    localparam int REG_WIN0 = 3;

    // Bit position of the limit page inside a window register.
    localparam int LIMIT_LSB = 16;

endpackage

// File: rtl/mwin_cfg_regs.sv
// Configuration register file for the decoder.
// Holds the mode bits, the top-of-memory page, the window enable mask,
// and the base and limit of each window. Window k < NWIN belongs to the
// compatibility bridge; window k >= NWIN belongs to the auxiliary bridge.
// Assumes PAGE_W <= 16, so each window fits one 32-bit register.
// Writes to unmapped indices are dropped.
module mwin_cfg_regs #(
    parameter int PAGE_W = 16,
    parameter int NWIN   = 4,
    parameter int CFG_AW = 4,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [CFG_AW-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    output logic                             multi_mode,
    output logic                             high_en,
    output logic [PAGE_W-1:0]                tom_page,
    output logic [2*NWIN-1:0]                win_en,
    output logic [2*NWIN-1:0][PAGE_W-1:0]    win_base,
    output logic [2*NWIN-1:0][PAGE_W-1:0]    win_limit
);
    import mwin_pkg::*;

    localparam int NTOT = 2 * NWIN;

    // Control, top-of-memory and enable mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            multi_mode <= 1'b0;
            high_en    <= 1'b0;
            tom_page   <= '0;
            win_en     <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(REG_CTRL)) begin
                multi_mode <= cfg_wdata[0];
                high_en    <= cfg_wdata[1];
            end
            if (cfg_addr == CFG_AW'(REG_TOM))
                tom_page <= cfg_wdata[PAGE_W-1:0];
            if (cfg_addr == CFG_AW'(REG_EN))
                win_en <= cfg_wdata[NTOT-1:0];
        end
    end

    for (genvar k = 0; k < NTOT; k++) begin : g_win
        // Base and limit page of window k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_base[k]  <= '0;
                win_limit[k] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(REG_WIN0 + k)) begin
                win_base[k]  <= cfg_wdata[PAGE_W-1:0];
                win_limit[k] <= cfg_wdata[LIMIT_LSB +: PAGE_W];
            end
        end
    end

endmodule

// File: rtl/mwin_range_match.sv
// Window comparator bank for one bridge.
// Reports whether the page falls in any enabled window, with inclusive
// base and limit. A window whose limit is below its base matches nothing.
module mwin_range_match #(
    parameter int PAGE_W = 16,
    parameter int NWIN   = 4
) (
    input  logic [PAGE_W-1:0]             page,
    input  logic [NWIN-1:0]               en,
    input  logic [NWIN-1:0][PAGE_W-1:0]   base,
    input  logic [NWIN-1:0][PAGE_W-1:0]   limit,
    output logic                          hit
);
    logic [NWIN-1:0] hit_vec;

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        // Compare the page against one window's bounds.
        assign hit_vec[w] = en[w] && (page >= base[w]) && (page <= limit[w]);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/mwin_decoder.sv
// Memory window decoder for a system with two host bridges.
// Maps a host physical address onto DRAM, the compatibility bridge,
// the auxiliary bridge or no target. The priority order is DRAM below
// top of memory, then the fixed excluded hole, then the bridge claims.
// A hit by both bridges is an overlap. Lookups are registered once, so
// the latency is one clock at one request per cycle.
// Assumes the excluded hole is given in page units.
module mwin_decoder #(
    parameter int ADDR_W       = 36,
    parameter int GRAN_SHIFT   = 20,
    parameter int NWIN         = 4,
    parameter int EXCL_BASE_PG = 'hFEC,
    parameter int EXCL_LIM_PG  = 'hFEC,
    parameter int DATA_W       = 32,
    parameter int CFG_AW       = $clog2(3 + 2 * NWIN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_target,
    output logic                 rsp_overlap
);
    import mwin_pkg::*;

    localparam int PAGE_W = ADDR_W - GRAN_SHIFT;

    logic                             cfg_multi;
    logic                             cfg_high;
    logic [PAGE_W-1:0]                cfg_tom;
    logic [2*NWIN-1:0]                cfg_en;
    logic [2*NWIN-1:0][PAGE_W-1:0]    cfg_base;
    logic [2*NWIN-1:0][PAGE_W-1:0]    cfg_limit;

    logic [PAGE_W-1:0]  req_page;
    logic               compat_win_hit;
    logic               aux_win_hit;
    logic               in_dram;
    logic               in_hole;
    logic               compat_claim;
    tgt_e               tgt_d;
    logic               ovl_d;

    assign req_page = req_addr[ADDR_W-1:GRAN_SHIFT];

    mwin_cfg_regs #(
        .PAGE_W (PAGE_W),
        .NWIN   (NWIN),
        .CFG_AW (CFG_AW),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .multi_mode (cfg_multi),
        .high_en    (cfg_high),
        .tom_page   (cfg_tom),
        .win_en     (cfg_en),
        .win_base   (cfg_base),
        .win_limit  (cfg_limit)
    );

    mwin_range_match #(.PAGE_W(PAGE_W), .NWIN(NWIN)) compat_match_i (
        .page  (req_page),
        .en    (cfg_en[NWIN-1:0]),
        .base  (cfg_base[NWIN-1:0]),
        .limit (cfg_limit[NWIN-1:0]),
        .hit   (compat_win_hit)
    );

    mwin_range_match #(.PAGE_W(PAGE_W), .NWIN(NWIN)) aux_match_i (
        .page  (req_page),
        .en    (cfg_en[2*NWIN-1:NWIN]),
        .base  (cfg_base[2*NWIN-1:NWIN]),
        .limit (cfg_limit[2*NWIN-1:NWIN]),
        .hit   (aux_win_hit)
    );

    assign in_dram      = req_page < cfg_tom;
    assign in_hole      = (req_page >= PAGE_W'(EXCL_BASE_PG)) && (req_page <= PAGE_W'(EXCL_LIM_PG));
    // The high range covers everything from top of memory up; DRAM is ruled out first.
    assign compat_claim = compat_win_hit || cfg_high;

    // Priority resolution between DRAM, the hole and the two bridges.
    always_comb begin
        tgt_d = TGT_NONE;
        ovl_d = 1'b0;
        if (in_dram) begin
            tgt_d = TGT_DRAM;
        end else if (in_hole) begin
            tgt_d = TGT_NONE;
        end else if (compat_claim && aux_win_hit) begin
            ovl_d = 1'b1;
        end else if (compat_claim) begin
            tgt_d = TGT_COMPAT;
        end else if (aux_win_hit) begin
            tgt_d = TGT_AUX;
        end else if (!cfg_multi) begin
            tgt_d = TGT_COMPAT;
        end
    end

    // Response pipeline stage: one clock of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_target  <= TGT_NONE;
            rsp_overlap <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_target  <= req_valid ? tgt_d : TGT_NONE;
            rsp_overlap <= req_valid && ovl_d;
        end
    end

endmodule

// File: rtl/mwin_decoder_chk.sv
// Property checker for the memory window decoder, bound into every
// instance. It watches the request and response ports together with the
// register-file outputs. The hole is recomputed here from the parameters.
module mwin_decoder_chk #(
    parameter int PAGE_W       = 16,
    parameter int EXCL_BASE_PG = 'hFEC,
    parameter int EXCL_LIM_PG  = 'hFEC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PAGE_W-1:0] page,
    input logic              rsp_valid,
    input logic [1:0]        rsp_target,
    input logic              rsp_overlap,
    input logic [PAGE_W-1:0] tom,
    input logic              multi,
    input logic              high
);
    import mwin_pkg::*;

    logic hole;
    assign hole = (page >= PAGE_W'(EXCL_BASE_PG)) && (page <= PAGE_W'(EXCL_LIM_PG));

    // R2: a request yields a response one edge later.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: an idle cycle yields no response one edge later.
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: a page below top of memory goes to DRAM.
    assert_dram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && page < tom) |=> (rsp_target == TGT_DRAM && !rsp_overlap));

    // R4: the hole is never claimed.
    assert_hole_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && page >= tom && hole) |=> (rsp_target == TGT_NONE && !rsp_overlap));

    // R8: the high range hands the compatibility bridge everything above top of memory.
    assert_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && high && page >= tom && !hole) |=> (rsp_overlap || rsp_target == TGT_COMPAT));

    // R9: in single-bridge mode, nothing outside the hole goes unclaimed.
    assert_subtractive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !multi && page >= tom && !hole) |=>
        (rsp_overlap || rsp_target == TGT_COMPAT || rsp_target == TGT_AUX));

    // R11: an overlap carries no target and only appears with a response.
    assert_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overlap |-> (rsp_valid && rsp_target == TGT_NONE));

endmodule

bind mwin_decoder mwin_decoder_chk #(
    .PAGE_W       (ADDR_W - GRAN_SHIFT),
    .EXCL_BASE_PG (EXCL_BASE_PG),
    .EXCL_LIM_PG  (EXCL_LIM_PG)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .page        (req_page),
    .rsp_valid   (rsp_valid),
    .rsp_target  (rsp_target),
    .rsp_overlap (rsp_overlap),
    .tom         (cfg_tom),
    .multi       (cfg_multi),
    .high        (cfg_high)
);

// File: tb/mwin_decoder_tb_top.sv
// Self-checking bench for the memory window decoder. It runs directed
// corner cases, then seeded random traffic, against a register model and
// a reference decode function.
module mwin_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic        rsp_overlap;

    int checks = 0;
    int errors = 0;

    // Register model
    logic [1:0]  m_ctrl = '0;
    logic [15:0] m_tom = '0;
    logic [7:0]  m_en = '0;
    logic [15:0] m_base [8];
    logic [15:0] m_lim  [8];

    // Pending lookup
    logic        pend_v = 1'b0;
    logic [2:0]  pend_exp = '0;
    string       pend_tag = "";

    always #10 clk = ~clk;

    mwin_decoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .rsp_valid   (rsp_valid),
        .rsp_target  (rsp_target),
        .rsp_overlap (rsp_overlap)
    );

    // Reference decode, returning {overlap, target}
    function automatic logic [2:0] exp_of(input logic [35:0] a);
        logic [15:0] pg;
        logic c;
        logic x;
        pg = a[35:20];
        if (pg < m_tom) return 3'b001;
        if (pg == 16'hFEC) return 3'b000;
        c = m_ctrl[1];
        x = 1'b0;
        for (int w = 0; w < 4; w++) begin
            if (m_en[w] && pg >= m_base[w] && pg <= m_lim[w]) c = 1'b1;
            if (m_en[w+4] && pg >= m_base[w+4] && pg <= m_lim[w+4]) x = 1'b1;
        end
        if (c && x) return 3'b100;
        if (c) return 3'b010;
        if (x) return 3'b011;
        if (!m_ctrl[0]) return 3'b010;
        return 3'b000;
    endfunction

    function automatic void model_write(input logic [3:0] wa, input logic [31:0] wd);
        case (wa)
            4'd0: m_ctrl = wd[1:0];
            4'd1: m_tom = wd[15:0];
            4'd2: m_en = wd[7:0];
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
                m_base[wa-4'd3] = wd[15:0];
                m_lim[wa-4'd3]  = wd[31:16];
            end
            default: ;
        endcase
    endfunction

    // One cycle: check the previous lookup, then drive this cycle's inputs.
    task automatic cyc(input logic rv, input logic [35:0] a, input logic we,
                       input logic [3:0] wa, input logic [31:0] wd, input string tag);
        @(negedge clk);
        checks++;
        if (rsp_valid !== pend_v) begin
            errors++;
            $display("FAIL R2 rsp_valid actual %0b expected %0b", rsp_valid, pend_v);
        end
        if (pend_v) begin
            checks++;
            if ({rsp_overlap, rsp_target} !== pend_exp) begin
                errors++;
                $display("FAIL %s addr-lookup ovl/tgt actual %0b/%0d expected %0b/%0d",
                         pend_tag, rsp_overlap, rsp_target, pend_exp[2], pend_exp[1:0]);
            end
        end
        req_valid = rv;
        req_addr  = a;
        cfg_we    = we;
        cfg_addr  = wa;
        cfg_wdata = wd;
        pend_v    = rv;
        pend_exp  = exp_of(a);
        pend_tag  = tag;
        if (we) model_write(wa, wd);
    endtask

    task automatic look(input logic [35:0] a, input string tag);
        cyc(1'b1, a, 1'b0, 4'd0, 32'd0, tag);
    endtask

    task automatic wr(input logic [3:0] wa, input logic [31:0] wd);
        cyc(1'b0, 36'd0, 1'b1, wa, wd, "R12");
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        for (int k = 0; k < 8; k++) begin
            m_base[k] = '0;
            m_lim[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: response invalid during reset
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rsp_valid in reset actual %0b expected 0", rsp_valid);
        end
        rst_n = 1'b1;

        // R1 / R9: reset state, subtractive decode to the compatibility bridge
        look(36'h0_0000_0000, "R1");
        look(36'h8_0000_0000, "R1");
        look(36'h0_FEC0_0000, "R4");
        // R12: a lookup in the same cycle as the mode write sees the old mode
        cyc(1'b1, 36'h1_0000_0000, 1'b1, 4'd0, 32'h1, "R12");
        look(36'h1_0000_0000, "R10");
        // R3: top of memory at 2 GiB
        wr(4'd1, 32'h0000_0800);
        look(36'h0_7FFF_FFFF, "R3");
        look(36'h0_8000_0000, "R10");
        // R7: programmed but disabled window
        wr(4'd3, {16'h09FF, 16'h0900});
        look(36'h0_9000_0000, "R7");
        // R5: enable compatibility window 0, test inclusive edges
        wr(4'd2, 32'h01);
        look(36'h0_9000_0000, "R5");
        look(36'h0_9FFF_FFFF, "R5");
        look(36'h0_A000_0000, "R5");
        look(36'h0_8FFF_FFFF, "R5");
        // R11: auxiliary window 1 straddles compatibility window 0
        wr(4'd8, {16'h0A10, 16'h09F0});
        wr(4'd2, 32'h21);
        look(36'h0_9F50_0000, "R11");
        look(36'h0_A050_0000, "R5");
        look(36'h0_9EFF_FFFF, "R5");
        // R6: inverted window
        wr(4'd9, {16'h0BFF, 16'h0C00});
        wr(4'd2, 32'h61);
        look(36'h0_BFF0_0000, "R6");
        look(36'h0_C000_0000, "R6");
        // R4: window covering the hole
        wr(4'd4, {16'h0FFF, 16'h0FE0});
        wr(4'd2, 32'h63);
        look(36'h0_FEC1_2345, "R4");
        look(36'h0_FE00_0000, "R5");
        look(36'h0_FED0_0000, "R5");
        // R3: top of memory now covers window 0
        wr(4'd1, 32'h0000_0A00);
        look(36'h0_9000_0000, "R3");
        // R13: unmapped index writes change nothing
        wr(4'd15, 32'hFFFF_FFFF);
        wr(4'd11, 32'hFFFF_FFFF);
        look(36'h2_0000_0000, "R13");
        look(36'h0_A050_0000, "R13");
        // R8: high range on
        wr(4'd0, 32'h3);
        look(36'h2_0000_0000, "R8");
        look(36'h0_A050_0000, "R11");
        look(36'h0_FEC0_0000, "R4");
        look(36'h0_0000_0000, "R3");

        // Random traffic around a dense page pool
        for (int n = 0; n < 4000; n++) begin
            logic        rv;
            logic [35:0] a;
            logic        we;
            logic [3:0]  wa;
            logic [31:0] wd;
            logic [15:0] b;
            logic [15:0] l;
            rv = ($urandom % 4) != 0;
            if (($urandom % 4) == 0)
                a = {$urandom, $urandom}[35:0];
            else
                a = {16'(16'hF70 + ($urandom % 288)), 20'($urandom)};
            we = ($urandom % 6) == 0;
            wa = 4'($urandom);
            b  = 16'(16'hF80 + ($urandom % 256));
            l  = 16'(b + ($urandom % 64) - 8);
            case (wa)
                4'd0: wd = 32'($urandom % 4);
                4'd1: wd = 32'(16'hF00 + ($urandom % 200));
                4'd2: wd = $urandom;
                default: wd = {l, b};
            endcase
            cyc(rv, a, we, wa, wd, "R5/R9/R12 random");
        end
        cyc(1'b0, 36'd0, 1'b0, 4'd0, 32'd0, "R2");
        cyc(1'b0, 36'd0, 1'b0, 4'd0, 32'd0, "R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule